// File: doc/BRIEF.md
# Interrupt Priority Masking Selector

This block decides which pending interrupt line may preempt the processor. Each line has an 8-bit priority field. Only the top `PRIO_BITS` bits of each field are stored, and the unstored low bits always read as zero. A lower number means a more urgent interrupt. Because the stored bits sit at the top of the byte, a build with fewer bits keeps the same order of priorities and only merges neighbouring levels.

A programmable threshold register blocks requests that are not urgent enough. The value zero turns the threshold off. The surrounding core supplies the priority of the interrupt it is running now. A request can only take over if it is strictly more urgent than that priority. Every stored bit counts as a preemption bit; there is no sub-priority.

The block makes its decision every cycle from the register contents, the request lines and the active priority. It reports the decision as a registered one-cycle strobe, together with the winning line number and that line's priority.

Top module: `irq_mask_select`

## Requirements
- R1: A priority write keeps only the top `PRIO_BITS` bits of the byte. Reading the line back through `prioRdIdx` shows those bits with every lower bit at zero. With 4 bits stored, writing 0x5A reads back as 0x50 and writing 0x37 reads back as 0x30.
- R2: The threshold register keeps only the top `PRIO_BITS` bits in the same way. With 4 bits stored, writing 0x6F reads back as 0x60.
- R3: Among the eligible requests, the one with the numerically smallest priority value wins.
- R4: When eligible requests tie on the best priority value, the lowest-numbered line wins.
- R5: A threshold value of zero masks no request, including requests at the least urgent level (0xF0 with 4 bits).
- R6: A nonzero threshold M blocks every request whose priority value is greater than or equal to M. M=0x60 blocks a line at 0x60 but passes a line at 0x50.
- R7: A request is eligible only if its priority value is strictly below `activePrio`. When `activeValid` is low, every level is eligible, as if the active priority were 0x100.
- R8: `takeIrq` is registered. It is high for exactly one cycle and is never high on two cycles in a row. In that cycle `takeIdx` and `takePrio` hold the winner chosen from the inputs of the previous cycle. In every other cycle both are zero.
- R9: After reset, every priority field and the threshold read as zero and `takeIrq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pendReq | input | NUM_LINES | Pending request per line |
| prioWrEn | input | 1 | Priority field write enable |
| prioWrIdx | input | IDX_W | Line whose priority is written |
| prioWrData | input | 8 | Priority byte to write |
| prioRdIdx | input | IDX_W | Line whose priority is read |
| prioRdData | output | 8 | Priority byte of the read line, low bits zero |
| maskWrEn | input | 1 | Threshold write enable |
| maskWrData | input | 8 | Threshold byte to write |
| maskRdData | output | 8 | Current threshold, low bits zero |
| activeValid | input | 1 | An interrupt is currently active |
| activePrio | input | 8 | Priority of the active interrupt |
| takeIrq | output | 1 | One-cycle preemption strobe |
| takeIdx | output | IDX_W | Winning line, valid with takeIrq |
| takePrio | output | 8 | Winning priority, valid with takeIrq |

## Verification
The assertions assume that `pendReq`, `activeValid` and `activePrio` are steady around each rising edge, because they relate the strobe to the values sampled one cycle earlier. They also assume the threshold does not change in the cycle before a strobe. The stimulus changes every input only on the falling edge. It writes registers only while no request is pending, and it releases the requests right after each checked strobe so that every scenario starts from an idle cycle.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  // Write strobes handed from the control to the datapath
  typedef struct packed {
    logic       prioWe;
    logic       maskWe;
    logic [7:0] wrByte;
  } ctrlStrobes_t;

  localparam int PRIO_FIELD_W = 8;
endpackage

// File: rtl/irq_sel_datapath.sv
module irq_sel_datapath
  import irq_sel_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int PRIO_BITS = 4,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic [IDX_W-1:0]     wrIdx,
  input  logic [NUM_LINES-1:0] pendReq,
  input  logic                 activeValid,
  input  logic [7:0]           activePrio,
  input  logic [IDX_W-1:0]     prioRdIdx,
  output logic [7:0]           prioRdData,
  output logic [7:0]           maskRdData,
  output logic                 winValid,
  output logic [IDX_W-1:0]     winIdx,
  output logic [7:0]           winPrio
);
  localparam int LOW_W = PRIO_FIELD_W - PRIO_BITS;

  logic [PRIO_BITS-1:0] prioStore [NUM_LINES];
  logic [PRIO_BITS-1:0] maskStore;
  logic [7:0]           prioFull  [NUM_LINES];
  logic [7:0]           maskFull;
  logic [8:0]           activeLim;
  logic [NUM_LINES-1:0] eligible;

  assign maskFull  = 8'(maskStore) << LOW_W;
  assign activeLim = activeValid ? {1'b0, activePrio} : 9'h100;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) maskStore <= '0;
    else if (strobes.maskWe) maskStore <= strobes.wrByte[7 -: PRIO_BITS];
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) prioStore[g] <= '0;
      else if (strobes.prioWe && (int'(wrIdx) == g))
        prioStore[g] <= strobes.wrByte[7 -: PRIO_BITS];
    end

    assign prioFull[g] = 8'(prioStore[g]) << LOW_W;

    assign eligible[g] = pendReq[g]
                       && !((maskFull != 8'h00) && (prioFull[g] >= maskFull))
                       && ({1'b0, prioFull[g]} < activeLim);
  end

  always_comb begin
    prioRdData = 8'h00;
    if (int'(prioRdIdx) < NUM_LINES) prioRdData = prioFull[prioRdIdx];
  end

  assign maskRdData = maskFull;

  // Scan from the top line down so that ties resolve to the lowest line
  always_comb begin
    winValid = 1'b0;
    winIdx   = '0;
    winPrio  = 8'h00;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (eligible[i] && (!winValid || (prioFull[i] <= winPrio))) begin
        winValid = 1'b1;
        winIdx   = IDX_W'(i);
        winPrio  = prioFull[i];
      end
    end
  end
endmodule

// File: rtl/irq_sel_ctrl.sv
module irq_sel_ctrl
  import irq_sel_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             prioWrEn,
  input  logic [IDX_W-1:0] prioWrIdx,
  input  logic [7:0]       prioWrData,
  input  logic             maskWrEn,
  input  logic [7:0]       maskWrData,
  input  logic             winValid,
  input  logic [IDX_W-1:0] winIdx,
  input  logic [7:0]       winPrio,
  output ctrlStrobes_t     strobes,
  output logic [IDX_W-1:0] wrIdx,
  output logic             takeIrq,
  output logic [IDX_W-1:0] takeIdx,
  output logic [7:0]       takePrio
);
  logic idxInRange;

  assign idxInRange = int'(prioWrIdx) < NUM_LINES;

  // A threshold write wins the shared data byte if both arrive together
  always_comb begin
    strobes.maskWe = maskWrEn;
    strobes.prioWe = prioWrEn && idxInRange && !maskWrEn;
    strobes.wrByte = maskWrEn ? maskWrData : prioWrData;
  end

  assign wrIdx = prioWrIdx;

  // One-cycle strobe; the cycle after it gives the core time to update
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      takeIrq  <= 1'b0;
      takeIdx  <= '0;
      takePrio <= 8'h00;
    end else if (winValid && !takeIrq) begin
      takeIrq  <= 1'b1;
      takeIdx  <= winIdx;
      takePrio <= winPrio;
    end else begin
      takeIrq  <= 1'b0;
      takeIdx  <= '0;
      takePrio <= 8'h00;
    end
  end
endmodule

// File: rtl/irq_mask_select.sv
module irq_mask_select
  import irq_sel_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int PRIO_BITS = 4,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] pendReq,
  input  logic                 prioWrEn,
  input  logic [IDX_W-1:0]     prioWrIdx,
  input  logic [7:0]           prioWrData,
  input  logic [IDX_W-1:0]     prioRdIdx,
  output logic [7:0]           prioRdData,
  input  logic                 maskWrEn,
  input  logic [7:0]           maskWrData,
  output logic [7:0]           maskRdData,
  input  logic                 activeValid,
  input  logic [7:0]           activePrio,
  output logic                 takeIrq,
  output logic [IDX_W-1:0]     takeIdx,
  output logic [7:0]           takePrio
);
  ctrlStrobes_t     strobes;
  logic [IDX_W-1:0] wrIdx;
  logic             winValid;
  logic [IDX_W-1:0] winIdx;
  logic [7:0]       winPrio;

  irq_sel_ctrl #(.NUM_LINES(NUM_LINES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .prioWrEn(prioWrEn), .prioWrIdx(prioWrIdx), .prioWrData(prioWrData),
    .maskWrEn(maskWrEn), .maskWrData(maskWrData),
    .winValid(winValid), .winIdx(winIdx), .winPrio(winPrio),
    .strobes(strobes), .wrIdx(wrIdx),
    .takeIrq(takeIrq), .takeIdx(takeIdx), .takePrio(takePrio)
  );

  irq_sel_datapath #(.NUM_LINES(NUM_LINES), .PRIO_BITS(PRIO_BITS)) u_dp (
    .clk(clk), .rstN(rstN),
    .strobes(strobes), .wrIdx(wrIdx),
    .pendReq(pendReq), .activeValid(activeValid), .activePrio(activePrio),
    .prioRdIdx(prioRdIdx), .prioRdData(prioRdData), .maskRdData(maskRdData),
    .winValid(winValid), .winIdx(winIdx), .winPrio(winPrio)
  );
endmodule

// File: rtl/irq_mask_select_chk.sv
module irq_mask_select_chk #(
  parameter int NUM_LINES = 8,
  parameter int PRIO_BITS = 4,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_LINES-1:0] pendReq,
  input logic [7:0]           prioRdData,
  input logic [7:0]           maskRdData,
  input logic                 activeValid,
  input logic [7:0]           activePrio,
  input logic                 takeIrq,
  input logic [IDX_W-1:0]     takeIdx,
  input logic [7:0]           takePrio
);
  localparam logic [7:0] KEEP = 8'hFF << (8 - PRIO_BITS);

  // R1
  prio_low_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (prioRdData & ~KEEP) == 8'h00);

  // R2
  mask_low_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskRdData & ~KEEP) == 8'h00);

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |=> !takeIrq);

  // R8
  idle_outputs_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !takeIrq |-> (takeIdx == '0 && takePrio == 8'h00));

  // R3
  winner_was_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> ((($past(pendReq) >> takeIdx) & NUM_LINES'(1)) != '0));

  // R6
  below_threshold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (takeIrq && $past(maskRdData) != 8'h00) |-> (takePrio < $past(maskRdData)));

  // R7
  preempts_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    (takeIrq && $past(activeValid)) |-> (takePrio < $past(activePrio)));
endmodule

bind irq_mask_select irq_mask_select_chk #(
  .NUM_LINES(NUM_LINES), .PRIO_BITS(PRIO_BITS)
) u_chk (
  .clk(clk), .rstN(rstN), .pendReq(pendReq),
  .prioRdData(prioRdData), .maskRdData(maskRdData),
  .activeValid(activeValid), .activePrio(activePrio),
  .takeIrq(takeIrq), .takeIdx(takeIdx), .takePrio(takePrio)
);

// File: tb/tb_irq_mask_select.sv
`timescale 1ns/1ps
module tb_irq_mask_select;
  localparam int N = 8;
  localparam int IW = 3;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] pendReq = '0;
  logic         prioWrEn = 1'b0;
  logic [IW-1:0] prioWrIdx = '0;
  logic [7:0]   prioWrData = 8'h00;
  logic [IW-1:0] prioRdIdx = '0;
  logic [7:0]   prioRdData;
  logic         maskWrEn = 1'b0;
  logic [7:0]   maskWrData = 8'h00;
  logic [7:0]   maskRdData;
  logic         activeValid = 1'b0;
  logic [7:0]   activePrio = 8'h00;
  logic         takeIrq;
  logic [IW-1:0] takeIdx;
  logic [7:0]   takePrio;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  irq_mask_select #(.NUM_LINES(N), .PRIO_BITS(4)) dut (
    .clk(clk), .rstN(rstN), .pendReq(pendReq),
    .prioWrEn(prioWrEn), .prioWrIdx(prioWrIdx), .prioWrData(prioWrData),
    .prioRdIdx(prioRdIdx), .prioRdData(prioRdData),
    .maskWrEn(maskWrEn), .maskWrData(maskWrData), .maskRdData(maskRdData),
    .activeValid(activeValid), .activePrio(activePrio),
    .takeIrq(takeIrq), .takeIdx(takeIdx), .takePrio(takePrio)
  );

  task automatic checkVal(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wrPrio(int idx, logic [7:0] val);
    @(negedge clk);
    prioWrEn = 1'b1; prioWrIdx = IW'(idx); prioWrData = val;
    @(negedge clk);
    prioWrEn = 1'b0;
  endtask

  task automatic wrMask(logic [7:0] val);
    @(negedge clk);
    maskWrEn = 1'b1; maskWrData = val;
    @(negedge clk);
    maskWrEn = 1'b0;
  endtask

  task automatic readPrio(string tag, int idx, int exp);
    @(negedge clk);
    prioRdIdx = IW'(idx);
    #1;
    checkVal(tag, int'(prioRdData), exp);
  endtask

  // Raise requests, check the strobe one edge later, then release and idle
  task automatic pendAndCheck(string tag, logic [N-1:0] p, bit expTake,
                              int expIdx, int expPrio);
    @(negedge clk);
    pendReq = p;
    @(posedge clk); #1;
    checkVal({tag, " take"}, int'(takeIrq), int'(expTake));
    if (expTake) begin
      checkVal({tag, " idx"}, int'(takeIdx), expIdx);
      checkVal({tag, " prio"}, int'(takePrio), expPrio);
    end
    @(negedge clk);
    pendReq = '0;
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    #1;
    checkVal("R9 take after reset", int'(takeIrq), 0);
    checkVal("R9 mask after reset", int'(maskRdData), 0);
    readPrio("R9 prio line 5 after reset", 5, 0);
  endtask

  task automatic t_setup_and_readback;
    wrPrio(0, 8'hF0);
    wrPrio(1, 8'h30);
    wrPrio(2, 8'h5A);
    wrPrio(3, 8'h37);
    wrPrio(4, 8'h60);
    readPrio("R1 line 2 0x5A", 2, 8'h50);
    readPrio("R1 line 3 0x37", 3, 8'h30);
    readPrio("R1 line 0 0xF0", 0, 8'hF0);
  endtask

  task automatic t_order;
    pendAndCheck("R3 lines 0,2", 8'b0000_0101, 1'b1, 2, 8'h50);
    pendAndCheck("R3 lines 0,1,4", 8'b0001_0011, 1'b1, 1, 8'h30);
    pendAndCheck("R4 tie lines 1,3", 8'b0000_1010, 1'b1, 1, 8'h30);
    pendAndCheck("R5 mask 0 passes 0xF0", 8'b0000_0001, 1'b1, 0, 8'hF0);
  endtask

  task automatic t_mask;
    wrMask(8'h6F);
    #1;
    checkVal("R2 mask 0x6F", int'(maskRdData), 8'h60);
    pendAndCheck("R6 line 4 at threshold", 8'b0001_0000, 1'b0, 0, 0);
    pendAndCheck("R6 line 0 above threshold", 8'b0000_0001, 1'b0, 0, 0);
    pendAndCheck("R6 lines 2,4", 8'b0001_0100, 1'b1, 2, 8'h50);
    wrMask(8'h00);
    pendAndCheck("R5 mask cleared line 4", 8'b0001_0000, 1'b1, 4, 8'h60);
  endtask

  task automatic t_active;
    @(negedge clk);
    activeValid = 1'b1; activePrio = 8'h50;
    pendAndCheck("R7 equal to active", 8'b0000_0100, 1'b0, 0, 0);
    pendAndCheck("R7 more urgent than active", 8'b0000_0110, 1'b1, 1, 8'h30);
    @(negedge clk);
    activeValid = 1'b0;
    pendAndCheck("R7 none active", 8'b0000_0001, 1'b1, 0, 8'hF0);
  endtask

  task automatic t_pulse;
    @(negedge clk);
    pendReq = 8'b0000_0010;
    @(posedge clk); #1;
    checkVal("R8 first cycle", int'(takeIrq), 1);
    @(posedge clk); #1;
    checkVal("R8 second cycle low", int'(takeIrq), 0);
    checkVal("R8 idx zero when idle", int'(takeIdx), 0);
    @(negedge clk);
    pendReq = '0;
    @(posedge clk); #1;
  endtask

  task automatic finishRun;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_setup_and_readback();
    t_order();
    t_mask();
    t_active();
    t_pulse();
    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule